// File: doc/BRIEF.md
# Oscillator Section Count Calibrator

This block tunes a two-oscillator Vernier time measurement. It picks how many parallel sections stay enabled in the slow gated ring oscillator and in the fast one, and it picks the Vernier coefficient k. The goal is that k fast stages span the same time as k−1 slow stages. The oscillators and their stage counters sit outside the block. The calibrator only sees the two stage counts, and it drives a run enable and a counter clear.

A `start` pulse loads the starting settings: the fast oscillator gets every section, the slow one gets one fewer, and k gets its configured initial value. Each trial clears the counters, runs both oscillators until the fast count reaches k, then stops them and judges the captured slow count.
- A slow count of k−1 leads to a validation run that counts 4k fast stages and needs exactly 4(k−1) slow stages.
- A count of k or more means the slow section count is one too high.
- A count of k−2 or less lowers the fast section count if the slow one was just lowered, and lowers k otherwise.

Each adjustment is followed by a new trial. A passed validation raises `done`. A failed validation, or an adjustment that would break a floor, raises `fail`. Either flag holds until the next `start`.

The states are:

| State | Role | Transitions |
|---|---|---|
| IDLE | Waits after reset. | Goes to CLEAR on `start`. |
| CLEAR | Pulses the counter clear. | Goes to RUN. |
| RUN | Runs the oscillators. | Goes to JUDGE when the fast count reaches k. |
| JUDGE | Applies the verdict. | Goes to VCLEAR on a match, FAIL at a floor, and CLEAR otherwise. |
| VCLEAR | Clears the counters before validation. | Goes to VRUN. |
| VRUN | Runs the oscillators for validation. | Goes to VJUDGE when the fast count reaches 4k. |
| VJUDGE | Checks the validation count. | Goes to DONE on a match and FAIL otherwise. |
| DONE | Holds `done`. | Goes to CLEAR on `start`. |
| FAIL | Holds `fail`. | Goes to CLEAR on `start`. |

Top module: `osc_cal_ctrl`

## Requirements
- R1: After reset, and again on each accepted `start`, `nsec_fast` = MAX_SEC (48), `nsec_slow` = MAX_SEC−1 (47) and `vern_k` = K_INIT (10). After reset `done`, `fail`, `osc_run` and `cnt_clear` are low.
- R2: Every run is preceded by exactly one cycle with `cnt_clear` high and `osc_run` low. `osc_run` then stays high until the fast count reaches the target, which is k for a trial and 4k for a validation run. The run therefore lasts k or 4k cycles when the fast count rises by one per cycle.
- R3: A trial whose captured slow count equals k−1 is followed by a validation run, with the settings unchanged.
- R4: A trial slow count of k or more lowers `nsec_slow` by one and marks the slow count as just lowered.
- R5: A trial slow count of k−2 or less, while the slow count is marked as just lowered, lowers `nsec_fast` by one and clears the mark.
- R6: A trial slow count of k−2 or less, without the mark, lowers `vern_k` by one.
- R7: A validation slow count of exactly 4(k−1) raises `done`. `done` and all settings then hold until the next `start`.
- R8: A validation slow count other than 4(k−1) raises `fail`, with the settings unchanged. `done` and `fail` are never high together.
- R9: If an adjustment would take `nsec_slow` or `nsec_fast` below MIN_SEC (3), or `vern_k` below 2, `fail` rises and the settings keep their last values.
- R10: `start` has no effect while a calibration is in progress. It does not re-clear the counters or change a run's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a calibration from the starting settings |
| fast_cnt | input | CNT_W | Stage count of the fast oscillator |
| slow_cnt | input | CNT_W | Stage count of the slow oscillator |
| osc_run | output | 1 | Enables both oscillators |
| cnt_clear | output | 1 | Clears both stage counters |
| nsec_slow | output | SW | Enabled sections of the slow oscillator |
| nsec_fast | output | SW | Enabled sections of the fast oscillator |
| vern_k | output | KW | Vernier coefficient k |
| done | output | 1 | Calibration confirmed |
| fail | output | 1 | Calibration could not converge |

## Verification
Two things meet in the same cycle:
- On the edge where the fast count first equals its target, the run ends and the slow count is captured together. The bench oscillator model stops the slow count at a scripted value, and each trial verdict, and so the final settings, is judged against that value.
- In the JUDGE cycle, a retune step and the floor check land together. Scripts that keep returning k, or that step k down to 2, drive the block into the floor. The bench then checks that `fail` rises and the settings stay at their last legal values.

A `start` pulse during a run checks that a run already in progress is left alone.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_JUDGE,
        ST_VCLEAR,
        ST_VRUN,
        ST_VJUDGE,
        ST_DONE,
        ST_FAIL
    } cal_state_e;

    typedef enum logic [2:0] {
        VD_MATCH,
        VD_SLOW_DN,
        VD_FAST_DN,
        VD_K_DN,
        VD_LIMIT
    } verdict_e;

endpackage

// File: rtl/osc_cal_window.sv
// Trial window: picks the fast-stage target, flags when it is reached,
// and holds the slow count captured at that moment.
module osc_cal_window #(
    parameter int CNT_W = 8,
    parameter int KW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_win,
    input  logic             capture,
    input  logic [KW-1:0]    k,
    input  logic [CNT_W-1:0] fast_cnt,
    input  logic [CNT_W-1:0] slow_cnt,
    output logic             reached,
    output logic [CNT_W-1:0] snap
);

    logic [CNT_W-1:0] k_ext;
    logic [CNT_W-1:0] target;

    assign k_ext   = CNT_W'(k);
    assign target  = long_win ? (k_ext << 2) : k_ext;
    assign reached = (fast_cnt >= target);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (capture) begin
            snap <= slow_cnt;
        end
    end

endmodule

// File: rtl/osc_cal_tuner.sv
// Settings registers and the retune verdict for one captured slow count.
module osc_cal_tuner
    import osc_cal_pkg::*;
#(
    parameter int MAX_SEC = 48,
    parameter int MIN_SEC = 3,
    parameter int K_INIT  = 10,
    parameter int CNT_W   = 8,
    parameter int SW      = 6,
    parameter int KW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             apply,
    input  logic [CNT_W-1:0] snap,
    output logic [SW-1:0]    nsec_slow,
    output logic [SW-1:0]    nsec_fast,
    output logic [KW-1:0]    k,
    output verdict_e         verdict,
    output logic             val_ok
);

    localparam logic [SW-1:0] SEC_TOP   = SW'(MAX_SEC);
    localparam logic [SW-1:0] SEC_SLOW0 = SW'(MAX_SEC - 1);
    localparam logic [SW-1:0] SEC_FLOOR = SW'(MIN_SEC);
    localparam logic [KW-1:0] K_START   = KW'(K_INIT);
    localparam logic [KW-1:0] K_FLOOR   = KW'(2);

    logic             slow_just_cut;
    logic [CNT_W-1:0] k_m1;

    assign k_m1   = CNT_W'(k) - CNT_W'(1);
    assign val_ok = (snap == (k_m1 << 2));

    always_comb begin
        if (snap == k_m1) begin
            verdict = VD_MATCH;
        end else if (snap > k_m1) begin
            verdict = (nsec_slow == SEC_FLOOR) ? VD_LIMIT : VD_SLOW_DN;
        end else if (slow_just_cut) begin
            verdict = (nsec_fast == SEC_FLOOR) ? VD_LIMIT : VD_FAST_DN;
        end else begin
            verdict = (k == K_FLOOR) ? VD_LIMIT : VD_K_DN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            nsec_fast     <= SEC_TOP;
            nsec_slow     <= SEC_SLOW0;
            k             <= K_START;
            slow_just_cut <= 1'b0;
        end else if (apply) begin
            unique case (verdict)
                VD_SLOW_DN: begin
                    nsec_slow     <= nsec_slow - 1'b1;
                    slow_just_cut <= 1'b1;
                end
                VD_FAST_DN: begin
                    nsec_fast     <= nsec_fast - 1'b1;
                    slow_just_cut <= 1'b0;
                end
                VD_K_DN: begin
                    k <= k - 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/osc_cal_seq.sv
// Calibration sequencer: state register, next state, and decoded outputs.
module osc_cal_seq
    import osc_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     reached,
    input  verdict_e verdict,
    input  logic     val_ok,
    output logic     osc_run,
    output logic     cnt_clear,
    output logic     long_win,
    output logic     capture,
    output logic     load,
    output logic     apply,
    output logic     done,
    output logic     fail
);

    cal_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CLEAR;
            ST_CLEAR:  state_nx = ST_RUN;
            ST_RUN:    if (reached) state_nx = ST_JUDGE;
            ST_JUDGE: begin
                unique case (verdict)
                    VD_MATCH: state_nx = ST_VCLEAR;
                    VD_LIMIT: state_nx = ST_FAIL;
                    default:  state_nx = ST_CLEAR;
                endcase
            end
            ST_VCLEAR: state_nx = ST_VRUN;
            ST_VRUN:   if (reached) state_nx = ST_VJUDGE;
            ST_VJUDGE: state_nx = val_ok ? ST_DONE : ST_FAIL;
            ST_DONE:   if (start) state_nx = ST_CLEAR;
            ST_FAIL:   if (start) state_nx = ST_CLEAR;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        osc_run   = 1'b0;
        cnt_clear = 1'b0;
        long_win  = 1'b0;
        capture   = 1'b0;
        load      = 1'b0;
        apply     = 1'b0;
        done      = 1'b0;
        fail      = 1'b0;
        unique case (state)
            ST_IDLE:   load = start;
            ST_CLEAR:  cnt_clear = 1'b1;
            ST_RUN: begin
                osc_run = 1'b1;
                capture = reached;
            end
            ST_JUDGE:  apply = 1'b1;
            ST_VCLEAR: begin
                cnt_clear = 1'b1;
                long_win  = 1'b1;
            end
            ST_VRUN: begin
                osc_run  = 1'b1;
                long_win = 1'b1;
                capture  = reached;
            end
            ST_VJUDGE: long_win = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            ST_FAIL: begin
                fail = 1'b1;
                load = start;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/osc_cal_ctrl.sv
// Top level of the oscillator section count calibrator.
module osc_cal_ctrl
    import osc_cal_pkg::*;
#(
    parameter int MAX_SEC = 48,
    parameter int MIN_SEC = 3,
    parameter int K_INIT  = 10,
    parameter int CNT_W   = 8,
    parameter int SW      = $clog2(MAX_SEC + 1),
    parameter int KW      = $clog2(K_INIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] fast_cnt,
    input  logic [CNT_W-1:0] slow_cnt,
    output logic             osc_run,
    output logic             cnt_clear,
    output logic [SW-1:0]    nsec_slow,
    output logic [SW-1:0]    nsec_fast,
    output logic [KW-1:0]    vern_k,
    output logic             done,
    output logic             fail
);

    logic             long_win;
    logic             capture;
    logic             load;
    logic             apply;
    logic             reached;
    logic             val_ok;
    logic [CNT_W-1:0] snap;
    verdict_e         verdict;

    osc_cal_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .reached   (reached),
        .verdict   (verdict),
        .val_ok    (val_ok),
        .osc_run   (osc_run),
        .cnt_clear (cnt_clear),
        .long_win  (long_win),
        .capture   (capture),
        .load      (load),
        .apply     (apply),
        .done      (done),
        .fail      (fail)
    );

    osc_cal_window #(
        .CNT_W (CNT_W),
        .KW    (KW)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_win (long_win),
        .capture  (capture),
        .k        (vern_k),
        .fast_cnt (fast_cnt),
        .slow_cnt (slow_cnt),
        .reached  (reached),
        .snap     (snap)
    );

    osc_cal_tuner #(
        .MAX_SEC (MAX_SEC),
        .MIN_SEC (MIN_SEC),
        .K_INIT  (K_INIT),
        .CNT_W   (CNT_W),
        .SW      (SW),
        .KW      (KW)
    ) u_tuner (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .apply     (apply),
        .snap      (snap),
        .nsec_slow (nsec_slow),
        .nsec_fast (nsec_fast),
        .k         (vern_k),
        .verdict   (verdict),
        .val_ok    (val_ok)
    );

endmodule

// File: rtl/osc_cal_ctrl_chk.sv
module osc_cal_ctrl_chk #(
    parameter int MAX_SEC = 48,
    parameter int MIN_SEC = 3,
    parameter int K_INIT  = 10,
    parameter int SW      = 6,
    parameter int KW      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          osc_run,
    input logic          cnt_clear,
    input logic [SW-1:0] nsec_slow,
    input logic [SW-1:0] nsec_fast,
    input logic [KW-1:0] vern_k,
    input logic          done,
    input logic          fail
);

    assert_clear_stops_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |-> !osc_run);

    assert_clear_then_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> osc_run);

    assert_run_keeps_settings_R3: assert property (@(posedge clk) disable iff (!rst_n)
        osc_run |-> ($stable(nsec_slow) && $stable(nsec_fast) && $stable(vern_k)));

    assert_slow_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nsec_slow != $past(nsec_slow)) |->
            (nsec_slow == $past(nsec_slow) - 1'b1 || nsec_slow == SW'(MAX_SEC - 1)));

    assert_k_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vern_k != $past(vern_k)) |->
            (vern_k == $past(vern_k) - 1'b1 || vern_k == KW'(K_INIT)));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=>
            (done && $stable(nsec_slow) && $stable(nsec_fast) && $stable(vern_k)));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_floors_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nsec_slow >= SW'(MIN_SEC)) && (nsec_fast >= SW'(MIN_SEC)) && (vern_k >= KW'(2)));

endmodule

bind osc_cal_ctrl osc_cal_ctrl_chk #(
    .MAX_SEC (MAX_SEC),
    .MIN_SEC (MIN_SEC),
    .K_INIT  (K_INIT),
    .SW      (SW),
    .KW      (KW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .osc_run   (osc_run),
    .cnt_clear (cnt_clear),
    .nsec_slow (nsec_slow),
    .nsec_fast (nsec_fast),
    .vern_k    (vern_k),
    .done      (done),
    .fail      (fail)
);

// File: tb/tb_osc_cal_ctrl.sv
module tb_osc_cal_ctrl;

    localparam int CNT_W = 8;
    localparam int SW    = 6;
    localparam int KW    = 4;
    localparam int NV    = 7;

    typedef struct packed {
        logic [9:0][7:0] resp;   // slow-count ceiling per run, first listed = run 0
        logic [5:0]      exp_nl;
        logic [5:0]      exp_nh;
        logic [3:0]      exp_k;
        logic            exp_done;
        logic            exp_fail;
    } vec_t;

    // k starts at 10: trial matches at 9, validation needs 36.
    localparam vec_t VECS [NV] = '{
        '{'{8'd9, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36}, 6'd47, 6'd48, 4'd10, 1'b1, 1'b0},
        '{'{8'd10, 8'd8, 8'd9, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36}, 6'd46, 6'd47, 4'd10, 1'b1, 1'b0},
        '{'{8'd8, 8'd8, 8'd32, 8'd32, 8'd32, 8'd32, 8'd32, 8'd32, 8'd32, 8'd32}, 6'd47, 6'd48, 4'd9, 1'b1, 1'b0},
        '{'{8'd9, 8'd35, 8'd35, 8'd35, 8'd35, 8'd35, 8'd35, 8'd35, 8'd35, 8'd35}, 6'd47, 6'd48, 4'd10, 1'b0, 1'b1},
        '{'{8'd10, 8'd10, 8'd9, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36, 8'd36}, 6'd45, 6'd48, 4'd10, 1'b1, 1'b0},
        '{'{8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0, 8'd0}, 6'd47, 6'd48, 4'd2, 1'b0, 1'b1},
        '{'{8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10}, 6'd3, 6'd48, 4'd10, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] fast_cnt = '0;
    logic [CNT_W-1:0] slow_cnt = '0;
    logic             osc_run;
    logic             cnt_clear;
    logic [SW-1:0]    nsec_slow;
    logic [SW-1:0]    nsec_fast;
    logic [KW-1:0]    vern_k;
    logic             done;
    logic             fail;

    int   checks = 0;
    int   errors = 0;
    vec_t cur_vec = VECS[0];
    int   base = 0;
    int   clears_seen = 0;
    int   cur_len = 0;
    int   len_hist [8];
    logic [7:0] slow_lim = '0;

    always #10 clk = ~clk;

    osc_cal_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fast_cnt  (fast_cnt),
        .slow_cnt  (slow_cnt),
        .osc_run   (osc_run),
        .cnt_clear (cnt_clear),
        .nsec_slow (nsec_slow),
        .nsec_fast (nsec_fast),
        .vern_k    (vern_k),
        .done      (done),
        .fail      (fail)
    );

    function automatic logic [7:0] pick(vec_t v, int i);
        int ii = (i > 9) ? 9 : ((i < 0) ? 0 : i);
        return v.resp[9 - ii];
    endfunction

    // Oscillator model: one fast stage per cycle, slow count follows up to its ceiling.
    always @(negedge clk) begin
        if (cnt_clear) begin
            if ((clears_seen - base) >= 1 && (clears_seen - base) <= 8)
                len_hist[clears_seen - base - 1] <= cur_len;
            fast_cnt    <= '0;
            slow_cnt    <= '0;
            cur_len     <= 0;
            slow_lim    <= pick(cur_vec, clears_seen - base);
            clears_seen <= clears_seen + 1;
        end else if (osc_run) begin
            fast_cnt <= fast_cnt + 1'b1;
            cur_len  <= cur_len + 1;
            if (slow_cnt < slow_lim) slow_cnt <= slow_cnt + 1'b1;
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_end(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done || fail) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic launch(vec_t v);
        @(negedge clk);
        cur_vec = v;
        base    = clears_seen;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_val("R1", "nsec_fast", nsec_fast, 48);
        check_val("R1", "nsec_slow", nsec_slow, 47);
        check_val("R1", "vern_k", vern_k, 10);
        check_val("R1", "done/fail/run/clear", {done, fail, osc_run, cnt_clear}, 0);

        // Table of scripted oscillator responses
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v]);
            wait_end(ok);
            check_val("R3-R9", $sformatf("vec%0d finished", v), ok, 1);
            check_val(VECS[v].exp_fail ? "R8_R9" : "R7", $sformatf("vec%0d done", v), done, VECS[v].exp_done);
            check_val(VECS[v].exp_fail ? "R8_R9" : "R7", $sformatf("vec%0d fail", v), fail, VECS[v].exp_fail);
            check_val(v == 6 ? "R9" : "R4", $sformatf("vec%0d nsec_slow", v), nsec_slow, VECS[v].exp_nl);
            check_val(v == 1 ? "R5" : "R4", $sformatf("vec%0d nsec_fast", v), nsec_fast, VECS[v].exp_nh);
            check_val(v == 5 ? "R9" : "R6", $sformatf("vec%0d vern_k", v), vern_k, VECS[v].exp_k);
        end

        // R2 run lengths and R7 hold after done
        launch(VECS[0]);
        wait_end(ok);
        check_val("R2", "trial run length", len_hist[0], 10);
        check_val("R2", "validation run length", cur_len, 40);
        check_val("R3", "runs per match", clears_seen - base, 2);
        repeat (15) @(negedge clk);
        check_val("R7", "done held", done, 1);
        check_val("R7", "settings held", {nsec_slow, nsec_fast, vern_k}, {6'd47, 6'd48, 4'd10});
        check_val("R7", "oscillators idle", osc_run, 0);

        // R1 restart from a retuned state reloads the starting settings
        launch(VECS[4]);
        wait_end(ok);
        check_val("R4", "retuned slow", nsec_slow, 45);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_val("R1", "reload slow", nsec_slow, 47);
        check_val("R1", "reload k", vern_k, 10);
        check_val("R1", "flags cleared", {done, fail}, 0);
        wait_end(ok);

        // R10 start during a run is ignored
        launch(VECS[0]);
        while (!osc_run) @(negedge clk);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_val("R10", "run continues", {osc_run, cnt_clear}, 2'b10);
        wait_end(ok);
        check_val("R10", "trial length unchanged", len_hist[0], 10);
        check_val("R10", "no extra clear", clears_seen - base, 2);
        check_val("R10", "result", done, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule